// File: doc/BRIEF.md
# USB Hub Downstream Port Line Driver

This block drives the data-line state of one downstream port of a USB hub. It holds the port's control bits: enable, low-speed select, forced reset and forced resume. From those bits it decides what the D+ and D- pins carry and when the port's transmitter is switched on. A 1 ms frame tick and a 1.5 Mb/s bit-rate clock enable pace the timed sequences. A fault input shuts the port off.

Two sequences are automatic. An enabled port receives a low-speed keep-awake end-of-packet on every frame tick. When the forced-resume bit is cleared, a low-speed end-of-packet is appended to close the resume. Software times how long reset and resume last; the block holds each forced state exactly as long as its bit is set. Line encodings are as follows. SE0 is D+=0, D-=0. Low-speed J is D+=0, D-=1 and low-speed K is D+=1, D-=0. Full-speed J and K are the inverse of these. A low-speed EOP is two bit times of SE0 followed by one bit time of low-speed J, whatever the speed bit says.

Top module: `usbp_port_drv`

## Requirements
- R1: After synchronous reset, port_en is 0 and drv_oe, dp_out and dm_out are all 0.
- R2: port_en becomes 1 only after a cycle with host_en_set high. sw_en_clr clears it. If set and clear arrive in the same cycle, the clear wins. Each change shows one cycle later.
- R3: A fault cycle clears port_en in the next cycle, overriding a simultaneous host_en_set. A fault does not alter the forced-state bits.
- R4: A keep-awake EOP starts one cycle after an accepted frame_tick. SE0 is driven until the cycle after the second bit_ce pulse, then low-speed J (drv_oe=1, dp=0, dm=1) until the cycle after the next bit_ce pulse. This holds whatever the low-speed bit says.
- R5: A frame_tick while port_en is 0 produces no line activity.
- R6: A frame_tick that arrives while an EOP is running, or while a forced reset or resume is set, is dropped. It neither restarts nor queues an EOP.
- R7: While the forced-reset bit is 1, the lines carry SE0 with drv_oe=1, starting one cycle after the write.
- R8: While the forced-resume bit is 1 and forced reset is 0, the lines carry K. This is dp=1, dm=0 when low_speed=1 and dp=0, dm=1 when low_speed=0. Any EOP in progress is abandoned.
- R9: A write that changes the forced-resume bit from 1 to 0, with the forced-reset bit 0, starts a fresh low-speed EOP (R4 timing) one cycle later.
- R10: Forced reset takes priority over forced resume. A resume bit that falls while reset is set produces no EOP.
- R11: When no forced state or EOP is active, drv_oe is 0 and dp_out and dm_out are 0. SE1 (both high) is never driven.
- R12: Reset clears the enable, low-speed, forced-reset and forced-resume bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en_set | input | 1 | Host-request pulse that enables the port |
| sw_en_clr | input | 1 | Software pulse that disables the port |
| fault | input | 1 | Fault pulse; disables the port |
| cfg_wr | input | 1 | Write strobe for the three configuration bits |
| cfg_low_speed | input | 1 | Write data: attached device is low speed |
| cfg_force_reset | input | 1 | Write data: force SE0 reset |
| cfg_force_resume | input | 1 | Write data: force K resume |
| frame_tick | input | 1 | 1 ms frame pulse |
| bit_ce | input | 1 | Low-speed bit-time clock enable |
| port_en | output | 1 | Port enable bit |
| drv_oe | output | 1 | Data-line drive enable |
| dp_out | output | 1 | D+ drive value |
| dm_out | output | 1 | D- drive value |

## Verification
Every output comes straight from registers. The result of any stimulus in cycle N is therefore due in cycle N+1: an enable change, a forced state, or the first SE0 cycle of an EOP. Each later EOP phase change is due one cycle after the bit_ce pulse that causes it. The driver tags every expected value with the cycle it is due in. The monitor compares only in that cycle, sampling at the falling edge, so a result that comes a cycle early or late is reported as a mismatch. Dropped ticks and ignored writes are checked the same way, by expecting the line state that must remain.

// File: rtl/usbp_pkg.sv
package usbp_pkg;

    typedef enum logic [1:0] {
        LN_OFF,
        LN_J,
        LN_K,
        LN_SE0
    } line_e;

    typedef enum logic [1:0] {
        EP_IDLE,
        EP_SE0,
        EP_J
    } eop_ph_e;

    typedef struct packed {
        logic low_speed;
        logic force_reset;
        logic force_resume;
    } port_ctl_t;

    typedef struct packed {
        logic oe;
        logic dp;
        logic dm;
    } drive_t;

    localparam int EOP_SE0_BITS = 2;
    localparam int EOP_J_BITS   = 1;

    // Map a symbolic line state to pin values; ls selects the J/K polarity.
    function automatic drive_t line_encode(line_e ln, logic ls);
        drive_t d;
        case (ln)
            LN_SE0:  d = '{oe: 1'b1, dp: 1'b0, dm: 1'b0};
            LN_J:    d = ls ? '{oe: 1'b1, dp: 1'b0, dm: 1'b1}
                            : '{oe: 1'b1, dp: 1'b1, dm: 1'b0};
            LN_K:    d = ls ? '{oe: 1'b1, dp: 1'b1, dm: 1'b0}
                            : '{oe: 1'b1, dp: 1'b0, dm: 1'b1};
            default: d = '{oe: 1'b0, dp: 1'b0, dm: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/usbp_port_regs.sv
module usbp_port_regs
    import usbp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      host_en_set,
    input  logic      sw_en_clr,
    input  logic      fault,
    input  logic      cfg_wr,
    input  port_ctl_t cfg_in,
    output logic      port_en,
    output port_ctl_t ctl_q,
    output port_ctl_t ctl_d,
    output logic      resume_end
);

    logic en_d;

    always_comb begin
        if (fault || sw_en_clr)
            en_d = 1'b0;
        else if (host_en_set)
            en_d = 1'b1;
        else
            en_d = port_en;
    end

    always_comb begin
        ctl_d = cfg_wr ? cfg_in : ctl_q;
    end

    // Resume bit written from 1 to 0 with no reset about to take over.
    assign resume_end = cfg_wr && ctl_q.force_resume
                        && !cfg_in.force_resume && !cfg_in.force_reset;

    always_ff @(posedge clk) begin
        if (rst) begin
            port_en <= 1'b0;
            ctl_q   <= '0;
        end else begin
            port_en <= en_d;
            ctl_q   <= ctl_d;
        end
    end

endmodule

// File: rtl/usbp_eop_gen.sv
module usbp_eop_gen
    import usbp_pkg::*;
#(
    parameter int SE0_BITS = EOP_SE0_BITS,
    parameter int J_BITS   = EOP_J_BITS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_ce,
    input  logic    hold,
    input  logic    start_resume,
    input  logic    start_keep,
    output eop_ph_e phase
);

    localparam int MAXB  = (SE0_BITS > J_BITS) ? SE0_BITS : J_BITS;
    localparam int CNT_W = $clog2(MAXB) + 1;
    localparam logic [CNT_W-1:0] SE0_LAST = CNT_W'(SE0_BITS - 1);
    localparam logic [CNT_W-1:0] J_LAST   = CNT_W'(J_BITS - 1);

    eop_ph_e          ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        ph_d  = phase;
        cnt_d = cnt_q;
        if (hold) begin
            ph_d  = EP_IDLE;
            cnt_d = '0;
        end else if (start_resume || (start_keep && phase == EP_IDLE)) begin
            ph_d  = EP_SE0;
            cnt_d = '0;
        end else if (bit_ce) begin
            case (phase)
                EP_SE0: begin
                    if (cnt_q == SE0_LAST) begin
                        ph_d  = EP_J;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                EP_J: begin
                    if (cnt_q == J_LAST) begin
                        ph_d  = EP_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    ph_d  = EP_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= EP_IDLE;
            cnt_q <= '0;
        end else begin
            phase <= ph_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/usbp_line_mux.sv
module usbp_line_mux
    import usbp_pkg::*;
(
    input  port_ctl_t ctl,
    input  eop_ph_e   phase,
    output drive_t    drv
);

    line_e ln;
    logic  ls_sel;

    always_comb begin
        ls_sel = 1'b1;
        if (ctl.force_reset) begin
            ln = LN_SE0;
        end else if (ctl.force_resume) begin
            ln     = LN_K;
            ls_sel = ctl.low_speed;
        end else if (phase == EP_SE0) begin
            ln = LN_SE0;
        end else if (phase == EP_J) begin
            ln = LN_J;
        end else begin
            ln = LN_OFF;
        end
        drv = line_encode(ln, ls_sel);
    end

endmodule

// File: rtl/usbp_port_drv.sv
module usbp_port_drv
    import usbp_pkg::*;
#(
    parameter int SE0_BITS = EOP_SE0_BITS,
    parameter int J_BITS   = EOP_J_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic host_en_set,
    input  logic sw_en_clr,
    input  logic fault,
    input  logic cfg_wr,
    input  logic cfg_low_speed,
    input  logic cfg_force_reset,
    input  logic cfg_force_resume,
    input  logic frame_tick,
    input  logic bit_ce,
    output logic port_en,
    output logic drv_oe,
    output logic dp_out,
    output logic dm_out
);

    port_ctl_t cfg_in, ctl_q, ctl_d;
    logic      resume_end, hold, start_keep;
    eop_ph_e   phase;
    drive_t    drv;

    assign cfg_in = '{low_speed: cfg_low_speed,
                      force_reset: cfg_force_reset,
                      force_resume: cfg_force_resume};

    usbp_port_regs regs_i (
        .clk        (clk),
        .rst        (rst),
        .host_en_set(host_en_set),
        .sw_en_clr  (sw_en_clr),
        .fault      (fault),
        .cfg_wr     (cfg_wr),
        .cfg_in     (cfg_in),
        .port_en    (port_en),
        .ctl_q      (ctl_q),
        .ctl_d      (ctl_d),
        .resume_end (resume_end)
    );

    assign hold       = ctl_d.force_reset || ctl_d.force_resume;
    assign start_keep = frame_tick && port_en;

    usbp_eop_gen #(
        .SE0_BITS(SE0_BITS),
        .J_BITS  (J_BITS)
    ) eop_i (
        .clk         (clk),
        .rst         (rst),
        .bit_ce      (bit_ce),
        .hold        (hold),
        .start_resume(resume_end),
        .start_keep  (start_keep),
        .phase       (phase)
    );

    usbp_line_mux mux_i (
        .ctl  (ctl_q),
        .phase(phase),
        .drv  (drv)
    );

    assign drv_oe = drv.oe;
    assign dp_out = drv.dp;
    assign dm_out = drv.dm;

endmodule

// File: rtl/usbp_port_drv_chk.sv
module usbp_port_drv_chk (
    input logic clk,
    input logic rst,
    input logic host_en_set,
    input logic fault,
    input logic cfg_wr,
    input logic cfg_force_reset,
    input logic cfg_force_resume,
    input logic resume_q,
    input logic port_en,
    input logic drv_oe,
    input logic dp_out,
    input logic dm_out
);

    AST_ENABLE_FROM_HOST: assert property (@(posedge clk) disable iff (rst)
        $rose(port_en) |-> $past(host_en_set)); // R2

    AST_FAULT_DISABLES: assert property (@(posedge clk) disable iff (rst)
        fault |=> !port_en); // R3

    AST_RESET_DRIVES_SE0: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_force_reset) |=> (drv_oe && !dp_out && !dm_out)); // R7

    AST_RESUME_END_EOP: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && resume_q && !cfg_force_resume && !cfg_force_reset)
        |=> (drv_oe && !dp_out && !dm_out)); // R9

    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (rst)
        !drv_oe |-> (!dp_out && !dm_out)); // R11

    AST_NO_SE1: assert property (@(posedge clk) disable iff (rst)
        !(dp_out && dm_out)); // R11

endmodule

bind usbp_port_drv usbp_port_drv_chk chk_i (
    .clk             (clk),
    .rst             (rst),
    .host_en_set     (host_en_set),
    .fault           (fault),
    .cfg_wr          (cfg_wr),
    .cfg_force_reset (cfg_force_reset),
    .cfg_force_resume(cfg_force_resume),
    .resume_q        (ctl_q.force_resume),
    .port_en         (port_en),
    .drv_oe          (drv_oe),
    .dp_out          (dp_out),
    .dm_out          (dm_out)
);

// File: tb/usbp_port_drv_tb_top.sv
module usbp_port_drv_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    // Expected-value encoding {port_en, drv_oe, dp, dm}
    localparam logic [3:0] OFF0 = 4'b0000;
    localparam logic [3:0] OFF1 = 4'b1000;
    localparam logic [3:0] SE01 = 4'b1100;
    localparam logic [3:0] LSJ1 = 4'b1101;
    localparam logic [3:0] LSK1 = 4'b1110;
    localparam logic [3:0] FSK1 = 4'b1101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_en_set = 0, sw_en_clr = 0, fault = 0, cfg_wr = 0;
    logic cfg_low_speed = 0, cfg_force_reset = 0, cfg_force_resume = 0;
    logic frame_tick = 0, bit_ce = 0;
    logic port_en, drv_oe, dp_out, dm_out;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int         due;
        logic [3:0] val;
        string      tag;
    } item_t;

    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usbp_port_drv dut_i (
        .clk(clk), .rst(rst), .host_en_set(host_en_set), .sw_en_clr(sw_en_clr),
        .fault(fault), .cfg_wr(cfg_wr), .cfg_low_speed(cfg_low_speed),
        .cfg_force_reset(cfg_force_reset), .cfg_force_resume(cfg_force_resume),
        .frame_tick(frame_tick), .bit_ce(bit_ce), .port_en(port_en),
        .drv_oe(drv_oe), .dp_out(dp_out), .dm_out(dm_out)
    );

    // Monitor: compare each expected item in the cycle it is due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if ({port_en, drv_oe, dp_out, dm_out} !== it.val) begin
                n_bad++;
                $display("FAIL %s cycle %0d actual=%b expected=%b", it.tag, cyc,
                         {port_en, drv_oe, dp_out, dm_out}, it.val);
            end
        end
    end

    // Driver: inputs staged at a falling edge are sampled at the next rising edge
    task automatic step(input logic [3:0] exp, input string tag);
        sb.push_back('{due: cyc + 1, val: exp, tag: tag});
        @(negedge clk);
        host_en_set = 0; sw_en_clr = 0; fault = 0; cfg_wr = 0;
        frame_tick = 0; bit_ce = 0;
    endtask

    task automatic wcfg(input logic ls, input logic rs, input logic rm);
        cfg_wr = 1; cfg_low_speed = ls; cfg_force_reset = rs; cfg_force_resume = rm;
    endtask

    initial begin
        @(negedge clk);
        // R1 reset state
        rst = 1; step(OFF0, "R1");
        step(OFF0, "R1");
        rst = 0;
        frame_tick = 1; step(OFF0, "R5 tick while disabled");
        bit_ce = 1;     step(OFF0, "R11 idle released");
        host_en_set = 1; step(OFF1, "R2 host enable");
        // R4 keep-awake EOP shape
        frame_tick = 1; step(SE01, "R4 eop start");
        bit_ce = 1;     step(SE01, "R4 se0 bit1");
        frame_tick = 1; step(SE01, "R6 tick during eop dropped");
        bit_ce = 1;     step(LSJ1, "R4 se0 to J");
        step(LSJ1, "R4 J held");
        bit_ce = 1;     step(OFF1, "R11 eop done released");
        // R8 low-speed resume, R6 tick dropped, R9 resume end
        wcfg(1, 0, 1);  step(LSK1, "R8 ls K");
        frame_tick = 1; step(LSK1, "R6 tick during resume");
        bit_ce = 1;     step(LSK1, "R8 K held");
        wcfg(1, 0, 0);  step(SE01, "R9 resume end eop");
        bit_ce = 1;     step(SE01, "R9 se0 bit1");
        bit_ce = 1;     step(LSJ1, "R9 J");
        bit_ce = 1;     step(OFF1, "R9 done");
        // R8 resume abandons a running EOP; fresh EOP after
        frame_tick = 1; step(SE01, "R4 eop start 2");
        wcfg(1, 0, 1);  step(LSK1, "R8 resume over eop");
        wcfg(1, 0, 0);  step(SE01, "R9 fresh eop");
        bit_ce = 1;     step(SE01, "R9 fresh se0 full length");
        bit_ce = 1;     step(LSJ1, "R9 fresh J");
        bit_ce = 1;     step(OFF1, "R9 fresh done");
        // Full-speed resume and R10 priority
        wcfg(0, 0, 1);  step(FSK1, "R8 fs K");
        wcfg(0, 1, 1);  step(SE01, "R10 reset over resume");
        wcfg(0, 0, 1);  step(FSK1, "R10 back to K");
        wcfg(0, 1, 0);  step(SE01, "R10 resume falls under reset");
        wcfg(0, 0, 0);  step(OFF1, "R10 no eop after reset");
        bit_ce = 1;     step(OFF1, "R10 still idle");
        // R4 keep-awake uses low-speed J even at full speed
        frame_tick = 1; step(SE01, "R4 fs port eop");
        bit_ce = 1;     step(SE01, "R4 fs se0");
        bit_ce = 1;     step(LSJ1, "R4 fs port ls J");
        bit_ce = 1;     step(OFF1, "R4 fs done");
        // R7 forced reset
        wcfg(1, 1, 0);  step(SE01, "R7 reset SE0");
        bit_ce = 1;     step(SE01, "R7 held");
        wcfg(1, 0, 0);  step(OFF1, "R7 released");
        // R3 fault, R2 set/clear
        host_en_set = 1; fault = 1; step(OFF0, "R3 fault over set");
        frame_tick = 1;  step(OFF0, "R5 tick after fault");
        host_en_set = 1; step(OFF1, "R2 re-enable");
        sw_en_clr = 1;   step(OFF0, "R2 sw clear");
        host_en_set = 1; sw_en_clr = 1; step(OFF0, "R2 clear wins");
        host_en_set = 1; step(OFF1, "R2 enable again");
        wcfg(1, 0, 1);   step(LSK1, "R8 K before fault");
        fault = 1;       step(4'b0110, "R3 fault keeps resume");
        // R12 reset clears everything
        rst = 1;         step(OFF0, "R12 reset");
        rst = 0;         step(OFF0, "R12 after reset");
        wcfg(0, 0, 0);   step(OFF0, "R12 resume bit was cleared");
        frame_tick = 1;  step(OFF0, "R12 enable was cleared");
        @(negedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard %0d items left actual=%0d expected=0",
                     sb.size(), sb.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= WATCHDOG);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule